// File: doc/BRIEF.md
# MESI Cache Line State Controller

This block holds the two-bit coherence state of every line of a small cache and works out, for each CPU access and each snoop cycle, the line's next state and the bus action it needs. Tag comparison, data storage and bus sequencing sit outside the block. The block receives a hit indication, and the outer logic acts on the requests that the block raises.

A CPU access brings a line index, a read or write type, a hit flag, a per-access write-back/write-through select and a flag saying whether a line fill can be done. A snoop brings its own index, a hit flag and an invalidate flag. A hit whose stored state is invalid counts as a miss. When a snoop and a CPU access land in the same cycle, the snoop is applied first, and the CPU access then sees the state the snoop left. A mode input restricts the block to the shared and invalid states and refuses writes, which suits an instruction cache.

All results are registered. They appear on the outputs one clock after the access or snoop is presented, and the state array updates on that same edge.

Top module: `mesi_line_ctrl`

## Requirements
- R1: Reset clears every line to invalid. The state encoding is I=2'b00, S=2'b01, E=2'b10, M=2'b11.
- R2: A read hit on a line in M, E or S reports the stored state, leaves it unchanged and raises no external write.
- R3: A read miss with a fill allowed reports and stores E when the write-back select is high and S when it is low, with no external write.
- R4: A read miss with no fill reports I, leaves the stored state unchanged and raises no external write. A hit flag on a line stored as I counts as a miss.
- R5: A write hit on an M or E line reports and stores M and raises no external write.
- R6: A write hit on an S line raises an external write. The line becomes E when the write-back select is high and stays S when it is low.
- R7: A write miss raises an external write, reports I and leaves the stored state unchanged.
- R8: A snoop hit on an M line raises the write-back-required output. The line becomes I when snoop-invalidate is set and S otherwise.
- R9: A snoop hit on an E or S line raises no write-back and moves the line to I (invalidate set) or S. A snoop on an I line, or with its hit flag low, changes nothing and reports the current state.
- R10: In instruction-cache mode, fills always produce S. Writes raise no external write and change no state.
- R11: When a snoop and a CPU access hit the same line in one cycle, the snoop is applied first, and the CPU access is decided from the post-snoop state.
- R12: Every result appears on the registered outputs one clock after its request, together with a done flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| icache_mode | input | 1 | Restricts lines to S/I and refuses writes |
| cpu_valid | input | 1 | CPU access present this cycle |
| cpu_write | input | 1 | 1 for write, 0 for read |
| cpu_idx | input | IW | Line index of the CPU access |
| cpu_hit | input | 1 | Tag match for the CPU access |
| wb_sel | input | 1 | 1 selects write-back handling, 0 write-through |
| fill_ok | input | 1 | A line fill can be done on a read miss |
| snp_valid | input | 1 | Snoop cycle present this cycle |
| snp_idx | input | IW | Line index of the snoop |
| snp_hit | input | 1 | Tag match for the snoop |
| snp_inv | input | 1 | Snoop asks for invalidation |
| acc_done_o | output | 1 | CPU result valid |
| acc_state_o | output | 2 | State of the accessed data after the access |
| ext_write_o | output | 1 | External write request |
| snp_done_o | output | 1 | Snoop result valid |
| snp_state_o | output | 2 | Line state after the snoop |
| snp_wb_o | output | 1 | Modified line must be written back |

## Verification
The embedded assertions watch, on every cycle, that read hits keep their state without bus traffic, that write hits on owned lines end in M with no external write, that write misses always go to the bus, that fills in instruction-cache mode yield S, and that a write-back request only comes with a snoop result. What the stored state becomes after each access, including the refusal of writes in instruction-cache mode and the snoop-first ordering when both paths target one line, only the bench's sweeps can show: they drive every start state against every access and snoop combination and read the stored state back with a probe read.

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int LINES = 16,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          icache_mode,
  input  logic          cpu_valid,
  input  logic          cpu_write,
  input  logic [IW-1:0] cpu_idx,
  input  logic          cpu_hit,
  input  logic          wb_sel,
  input  logic          fill_ok,
  input  logic          snp_valid,
  input  logic [IW-1:0] snp_idx,
  input  logic          snp_hit,
  input  logic          snp_inv,
  output logic          acc_done_o,
  output logic [1:0]    acc_state_o,
  output logic          ext_write_o,
  output logic          snp_done_o,
  output logic [1:0]    snp_state_o,
  output logic          snp_wb_o
);

  localparam logic [1:0] ST_I = 2'b00;
  localparam logic [1:0] ST_S = 2'b01;
  localparam logic [1:0] ST_E = 2'b10;
  localparam logic [1:0] ST_M = 2'b11;

  logic [1:0] st_q [LINES];

  logic [1:0] snp_cur, snp_nxt, cpu_base, cpu_res;
  logic       snp_act, cpu_hit_eff, cpu_store, cpu_ext;

  assign snp_cur     = st_q[snp_idx];
  assign snp_act     = snp_valid && snp_hit && (snp_cur != ST_I);
  assign snp_nxt     = snp_inv ? ST_I : ST_S;
  assign cpu_base    = (snp_act && snp_idx == cpu_idx) ? snp_nxt : st_q[cpu_idx];
  assign cpu_hit_eff = cpu_hit && (cpu_base != ST_I);

  always_comb begin
    cpu_res   = ST_I;
    cpu_store = 1'b0;
    cpu_ext   = 1'b0;
    if (!cpu_write) begin
      if (cpu_hit_eff) begin
        cpu_res = cpu_base;
      end else if (fill_ok) begin
        cpu_res   = (wb_sel && !icache_mode) ? ST_E : ST_S;
        cpu_store = 1'b1;
      end
    end else if (icache_mode) begin
      cpu_res = cpu_hit_eff ? cpu_base : ST_I;
    end else if (cpu_hit_eff) begin
      cpu_store = 1'b1;
      if (cpu_base == ST_S) begin
        cpu_ext = 1'b1;
        cpu_res = wb_sel ? ST_E : ST_S;
      end else begin
        cpu_res = ST_M;
      end
    end else begin
      cpu_ext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
      acc_done_o  <= 1'b0;
      acc_state_o <= ST_I;
      ext_write_o <= 1'b0;
      snp_done_o  <= 1'b0;
      snp_state_o <= ST_I;
      snp_wb_o    <= 1'b0;
    end else begin
      if (snp_act) st_q[snp_idx] <= snp_nxt;
      if (cpu_valid && cpu_store) st_q[cpu_idx] <= cpu_res;
      acc_done_o  <= cpu_valid;
      acc_state_o <= cpu_valid ? cpu_res : ST_I;
      ext_write_o <= cpu_valid && cpu_ext;
      snp_done_o  <= snp_valid;
      snp_state_o <= snp_valid ? (snp_act ? snp_nxt : snp_cur) : ST_I;
      snp_wb_o    <= snp_act && (snp_cur == ST_M);
    end
  end

  assert_rdhit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_valid && !cpu_write && cpu_hit_eff) |-> (acc_state_o == $past(cpu_base)) && !ext_write_o);

  assert_wrhit_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_valid && cpu_write && !icache_mode && cpu_hit_eff && cpu_base[1]) |-> (acc_state_o == ST_M) && !ext_write_o);

  assert_wrmiss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_valid && cpu_write && !icache_mode && !cpu_hit_eff) |-> ext_write_o && (acc_state_o == ST_I));

  assert_icache_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_valid && icache_mode && !cpu_write && !cpu_hit_eff && fill_ok) |-> (acc_state_o == ST_S));

  assert_icache_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_valid && icache_mode) |-> !ext_write_o);

  assert_wb_with_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb_o |-> snp_done_o && (snp_state_o == ($past(snp_inv) ? ST_I : ST_S)));

  assert_done_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_valid) |-> acc_done_o);

endmodule

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctrl;
  localparam int LINES = 16;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic icache_mode = 0, cpu_valid = 0, cpu_write = 0, cpu_hit = 0, wb_sel = 0, fill_ok = 0;
  logic snp_valid = 0, snp_hit = 0, snp_inv = 0;
  logic [IW-1:0] cpu_idx = '0, snp_idx = '0;
  logic acc_done_o, ext_write_o, snp_done_o, snp_wb_o;
  logic [1:0] acc_state_o, snp_state_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.LINES(LINES)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic cv, cw, ch, wb, fl, input logic [IW-1:0] ci,
                      input logic sv, sh, si, input logic [IW-1:0] sx);
    cpu_valid = cv; cpu_write = cw; cpu_hit = ch; wb_sel = wb; fill_ok = fl; cpu_idx = ci;
    snp_valid = sv; snp_hit = sh; snp_inv = si; snp_idx = sx;
    @(negedge clk);
    cpu_valid = 0; snp_valid = 0;
  endtask

  task automatic probe(input logic [IW-1:0] ix, output logic [1:0] st);
    step(1, 0, 1, 0, 0, ix, 0, 0, 0, '0);
    st = acc_state_o;
  endtask

  task automatic setup(input logic [IW-1:0] ix, input int st);
    step(0, 0, 0, 0, 0, '0, 1, 1, 1, ix);
    if (st == 1) step(1, 0, 0, 0, 1, ix, 0, 0, 0, '0);
    if (st >= 2) step(1, 0, 0, 1, 1, ix, 0, 0, 0, '0);
    if (st == 3) step(1, 1, 1, 0, 0, ix, 0, 0, 0, '0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] got;
    int n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R12 done idle", acc_done_o, 0);
    for (int i = 0; i < LINES; i++) begin
      probe(i[IW-1:0], got);
      chk("R1 reset state", got, 0);
    end
    for (int md = 0; md < 2; md++) begin
      icache_mode = md[0];
      for (int st = 0; st < (md ? 2 : 4); st++) begin
        for (int kind = 0; kind < 3; kind++) begin
          for (int a = 0; a < 8; a++) begin
            logic h, w, f;
            int e_state, e_store, e_ext, e_wb;
            logic [IW-1:0] ix;
            h = a[0]; w = a[1]; f = a[2];
            ix = n[IW-1:0]; n++;
            setup(ix, st);
            e_ext = 0; e_wb = 0; e_store = st;
            if (kind == 0) begin
              if (h && st != 0) e_state = st;                                   // R2
              else if (f) begin e_state = (w && !md) ? 2 : 1; e_store = e_state; end // R3 R10
              else e_state = 0;                                                 // R4
              step(1, 0, h, w, f, ix, 0, 0, 0, '0);
              chk("R2-R4 read state", acc_state_o, e_state);
              chk("R2 R3 R4 read no bus", ext_write_o, e_ext);
              chk("R12 done", acc_done_o, 1);
            end else if (kind == 1) begin
              if (md) e_state = (h && st != 0) ? st : 0;                        // R10
              else if (h && st >= 2) begin e_state = 3; e_store = 3; end        // R5
              else if (h && st == 1) begin e_ext = 1; e_state = w ? 2 : 1; e_store = e_state; end // R6
              else begin e_ext = 1; e_state = 0; end                            // R7
              step(1, 1, h, w, f, ix, 0, 0, 0, '0);
              chk("R5-R7 R10 write state", acc_state_o, e_state);
              chk("R5-R7 R10 write ext", ext_write_o, e_ext);
            end else begin
              if (h && st != 0) begin
                e_state = w ? 0 : 1; e_store = e_state; e_wb = (st == 3);       // R8 R9
              end else e_state = st;                                            // R9
              step(0, 0, 0, 0, 0, '0, 1, h, w, ix);
              chk("R8 R9 snoop state", snp_state_o, e_state);
              chk("R8 writeback", snp_wb_o, e_wb);
            end
            probe(ix, got);
            chk("R2-R10 stored state", got, e_store);
          end
        end
      end
    end
    icache_mode = 0;
    setup(4'd3, 3);
    step(1, 0, 1, 0, 0, 4'd3, 1, 1, 1, 4'd3);
    chk("R11 snoop wb", snp_wb_o, 1);
    chk("R11 cpu sees I", acc_state_o, 0);
    probe(4'd3, got);
    chk("R11 stored", got, 0);
    setup(4'd4, 2);
    step(1, 1, 1, 1, 0, 4'd4, 1, 1, 0, 4'd4);
    chk("R11 snoop to S", snp_state_o, 1);
    chk("R11 write on S ext", ext_write_o, 1);
    chk("R11 write result", acc_state_o, 2);
    probe(4'd4, got);
    chk("R11 stored", got, 2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule